// File: doc/BRIEF.md
# Remote DMA Data Port Engine

This block lets a host move bytes between a data port and a local packet buffer without addressing each byte. The host loads a 16-bit buffer address and a 16-bit byte count, one byte register at a time, then writes a command that starts a read or a write transfer. Each data-port access moves one byte in byte mode, or two bytes in word mode. Each access advances the address and lowers the remaining count.

When the count reaches zero, the engine goes idle and raises a done flag in a status register. The host clears that flag by writing a one to its bit. A typical write sequence is: clear the flag, program the address and count, issue the write command, push the data, then poll the flag. Data-port accesses outside an active transfer of the matching direction have no effect, and they read back as zero.

The buffer is held inside the block. It is indexed by the low `BUF_AW` bits of the 16-bit address. The host-side register interface is a single write strobe with a select. Reads are combinational from the select.

Top module: `rdma_port_engine`

## Requirements
- R1: After reset, the address, count, command and status registers all read 0, `done_flag` is 0 and `port_rdata` is 0.
- R2: Register select 0 and 1 load the address low and high byte, and select 2 and 3 load the count low and high byte. Reading the same selects returns the current address and the remaining count.
- R3: Select 4 is the command register. Bit 1 is go, bit 0 is halt, and bits 5:3 are the transfer field: 001 is read, 010 is write, and any value with bit 5 set is abort. A transfer starts only when go=1, halt=0 and the field is read or write. Any other command write leaves the engine idle, and later port accesses are ignored.
- R4: In byte mode (`word_mode`=0), each accepted access moves the byte at the current address on lane 7:0 and returns 0 on lane 15:8. It then adds 1 to the address and subtracts 1 from the count.
- R5: In word mode, each access moves the byte at the current address on lane 7:0 and the next byte on lane 15:8. It adds 2 to the address and subtracts 2 from the count, saturating at 0, so a transfer takes (count+1)/2 accesses. When one byte remains, only the low lane is written, and a read returns 0 on the high lane.
- R6: The address wraps modulo 2^16, and the buffer byte used is the address modulo 2^BUF_AW.
- R7: The access that brings the count to zero sets status bit 6 and `done_flag` at that same clock edge, and the engine goes idle. Starting a read or write with a count of zero sets the flag at the command's edge.
- R8: Status select 5 reads the flag in bit 6. Writing a byte with bit 6 set (0x40 or 0xFF) clears the flag. Writing a byte with bit 6 clear leaves it unchanged.
- R9: While idle, or on an access of the wrong direction, port reads return 0, port writes leave the buffer unchanged, and the address and count do not move.
- R10: An abort command during a transfer makes the engine idle without setting the flag. The address and count keep the values they had at that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_sel` |
| word_mode | input | 1 | 1: two bytes per port access, 0: one byte |
| port_rd | input | 1 | Data-port read strobe |
| port_wr | input | 1 | Data-port write strobe |
| port_wdata | input | 16 | Data-port write data, low byte on 7:0 |
| port_rdata | output | 16 | Data-port read data, low byte on 7:0 |
| done_flag | output | 1 | Transfer-complete flag (status bit 6) |

## Verification
Register writes and accepted port accesses take effect at the rising edge that samples their strobe. The bench drives each strobe from one falling edge to the next, so every updated address, count, flag and buffer byte is due on the falling edge right after that strobe. Read data are combinational: `port_rdata` and `reg_rdata` are sampled 1 ns after the strobe or select is set, which is before the edge that advances the address. The done flag is checked on the falling edge after the final access, or after a zero-count command, and its absence is checked after an abort.

// File: rtl/rdma_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and types of the remote DMA port engine.
// Assumes a byte-wide register interface and a 16-bit buffer pointer.
package rdma_pkg;
    localparam int BYTE_W = 8;
    localparam int PTR_W  = 2 * BYTE_W;

    // Register selects
    localparam logic [2:0] REG_ADDR_LO = 3'd0;
    localparam logic [2:0] REG_ADDR_HI = 3'd1;
    localparam logic [2:0] REG_CNT_LO  = 3'd2;
    localparam logic [2:0] REG_CNT_HI  = 3'd3;
    localparam logic [2:0] REG_CMD     = 3'd4;
    localparam logic [2:0] REG_STAT    = 3'd5;

    // Command byte layout
    localparam int CMD_HALT_BIT = 0;
    localparam int CMD_GO_BIT   = 1;
    localparam int CMD_FLD_LSB  = 3;
    localparam logic [2:0] FLD_READ  = 3'b001;
    localparam logic [2:0] FLD_WRITE = 3'b010;

    // Status byte layout
    localparam int DONE_BIT = 6;

    typedef enum logic [1:0] {
        XF_IDLE  = 2'd0,
        XF_READ  = 2'd1,
        XF_WRITE = 2'd2
    } xfer_mode_e;
endpackage

// File: rtl/rdma_buf_ram.sv
`timescale 1ns/1ps
// Module: byte-organised packet buffer with two byte lanes.
// Assumes the two lane addresses differ; reads are asynchronous and
// writes happen at the clock edge. Contents are not reset.
module rdma_buf_ram #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          we_lo,
    input  logic          we_hi,
    input  logic [AW-1:0] addr_lo,
    input  logic [AW-1:0] addr_hi,
    input  logic [7:0]    wd_lo,
    input  logic [7:0]    wd_hi,
    output logic [7:0]    rd_lo,
    output logic [7:0]    rd_hi
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    // Lane writes into the byte array
    always_ff @(posedge clk) begin
        if (we_lo) mem[addr_lo] <= wd_lo;
        if (we_hi) mem[addr_hi] <= wd_hi;
    end

    // Asynchronous lane reads
    assign rd_lo = mem[addr_lo];
    assign rd_hi = mem[addr_hi];
endmodule

// File: rtl/rdma_xfer_ctrl.sv
`timescale 1ns/1ps
// Module: address/count registers, command decode and transfer sequencing.
// Assumes register writes take priority over a port access in the same
// cycle (the access is then not taken). done_now is combinational.
module rdma_xfer_ctrl
    import rdma_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [2:0]           cfg_sel,
    input  logic [BYTE_W-1:0]    cfg_wdata,
    input  logic                 word_mode,
    input  logic                 port_rd,
    input  logic                 port_wr,
    output logic [PTR_W-1:0]     addr_q,
    output logic [PTR_W-1:0]     count_q,
    output logic [BYTE_W-1:0]    cmd_q,
    output xfer_mode_e           mode_q,
    output logic                 take_rd,
    output logic                 take_wr,
    output logic                 lone_byte,
    output logic                 done_now
);
    logic [PTR_W-1:0] step_sz;
    logic [PTR_W-1:0] next_cnt;
    logic [2:0]       fld;
    logic             go_cmd;
    logic             acc_ok;

    // Command field and start decode
    assign fld    = cfg_wdata[CMD_FLD_LSB +: 3];
    assign go_cmd = cfg_we && (cfg_sel == REG_CMD) && cfg_wdata[CMD_GO_BIT]
                    && !cfg_wdata[CMD_HALT_BIT]
                    && ((fld == FLD_READ) || (fld == FLD_WRITE));

    // Per-access step and saturating remaining count
    assign step_sz   = word_mode ? PTR_W'(2) : PTR_W'(1);
    assign next_cnt  = (count_q > step_sz) ? (count_q - step_sz) : '0;
    assign take_rd   = (mode_q == XF_READ)  && port_rd && !cfg_we;
    assign take_wr   = (mode_q == XF_WRITE) && port_wr && !cfg_we;
    assign acc_ok    = take_rd || take_wr;
    assign lone_byte = word_mode && (count_q == PTR_W'(1));
    assign done_now  = (acc_ok && (next_cnt == '0)) || (go_cmd && (count_q == '0));

    // Register loads, command handling and per-access advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            count_q <= '0;
            cmd_q   <= '0;
            mode_q  <= XF_IDLE;
        end else if (cfg_we) begin
            case (cfg_sel)
                REG_ADDR_LO: addr_q[BYTE_W-1:0]      <= cfg_wdata;
                REG_ADDR_HI: addr_q[PTR_W-1:BYTE_W]  <= cfg_wdata;
                REG_CNT_LO:  count_q[BYTE_W-1:0]     <= cfg_wdata;
                REG_CNT_HI:  count_q[PTR_W-1:BYTE_W] <= cfg_wdata;
                REG_CMD: begin
                    cmd_q <= cfg_wdata;
                    if (go_cmd && (count_q != '0))
                        mode_q <= (fld == FLD_READ) ? XF_READ : XF_WRITE;
                    else
                        mode_q <= XF_IDLE;
                end
                default: ;
            endcase
        end else if (acc_ok) begin
            addr_q  <= addr_q + step_sz;
            count_q <= next_cnt;
            if (next_cnt == '0) mode_q <= XF_IDLE;
        end
    end

    // R9: an idle engine with no register write keeps address and count
    a_r9_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == XF_IDLE && !cfg_we) |=> ($stable(addr_q) && $stable(count_q)));

    // R7: completion always leaves the engine idle
    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_now |=> (mode_q == XF_IDLE));
endmodule

// File: rtl/rdma_status.sv
`timescale 1ns/1ps
// Module: write-one-to-clear completion flag.
// Assumes set and clear are single-cycle pulses; a set takes priority.
module rdma_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // Sticky flag with set priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    // R7: a completion event is visible after the edge
    a_r7_set_seen: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag);

    // R8: a one written to the flag bit clears it
    a_r8_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !flag);

    // R8: without set or clear the flag holds
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !set) |=> $stable(flag));
endmodule

// File: rtl/rdma_port_engine.sv
`timescale 1ns/1ps
// Module: top of the remote DMA data port engine. Ties the sequencer,
// the packet buffer and the status flag together and muxes read data.
// Assumes BUF_AW <= 16; the buffer is indexed by the low address bits.
module rdma_port_engine
    import rdma_pkg::*;
#(
    parameter int BUF_AW = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_sel,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic        word_mode,
    input  logic        port_rd,
    input  logic        port_wr,
    input  logic [15:0] port_wdata,
    output logic [15:0] port_rdata,
    output logic        done_flag
);
    logic [PTR_W-1:0]  addr_q;
    logic [PTR_W-1:0]  count_q;
    logic [BYTE_W-1:0] cmd_q;
    xfer_mode_e        mode_q;
    logic              take_rd;
    logic              take_wr;
    logic              lone_byte;
    logic              done_now;
    logic [BUF_AW-1:0] idx_lo;
    logic [BUF_AW-1:0] idx_hi;
    logic              we_lo;
    logic              we_hi;
    logic [7:0]        rd_lo;
    logic [7:0]        rd_hi;
    logic              stat_clr;
    logic [7:0]        stat_byte;

    rdma_xfer_ctrl i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (reg_we),
        .cfg_sel   (reg_sel),
        .cfg_wdata (reg_wdata),
        .word_mode (word_mode),
        .port_rd   (port_rd),
        .port_wr   (port_wr),
        .addr_q    (addr_q),
        .count_q   (count_q),
        .cmd_q     (cmd_q),
        .mode_q    (mode_q),
        .take_rd   (take_rd),
        .take_wr   (take_wr),
        .lone_byte (lone_byte),
        .done_now  (done_now)
    );

    // Lane indices: low lane at the current address, high lane next byte
    assign idx_lo = addr_q[BUF_AW-1:0];
    assign idx_hi = addr_q[BUF_AW-1:0] + 1'b1;
    assign we_lo  = take_wr;
    assign we_hi  = take_wr && word_mode && !lone_byte;

    rdma_buf_ram #(.AW(BUF_AW)) i_buf (
        .clk     (clk),
        .we_lo   (we_lo),
        .we_hi   (we_hi),
        .addr_lo (idx_lo),
        .addr_hi (idx_hi),
        .wd_lo   (port_wdata[7:0]),
        .wd_hi   (port_wdata[15:8]),
        .rd_lo   (rd_lo),
        .rd_hi   (rd_hi)
    );

    assign stat_clr = reg_we && (reg_sel == REG_STAT) && reg_wdata[DONE_BIT];

    rdma_status i_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (done_now),
        .clr   (stat_clr),
        .flag  (done_flag)
    );

    // Data-port read lanes, zero outside an active read
    always_comb begin
        port_rdata = '0;
        if (mode_q == XF_READ) begin
            port_rdata[7:0] = rd_lo;
            if (word_mode && !lone_byte) port_rdata[15:8] = rd_hi;
        end
    end

    // Register read-back mux
    always_comb begin
        stat_byte           = '0;
        stat_byte[DONE_BIT] = done_flag;
        case (reg_sel)
            REG_ADDR_LO: reg_rdata = addr_q[BYTE_W-1:0];
            REG_ADDR_HI: reg_rdata = addr_q[PTR_W-1:BYTE_W];
            REG_CNT_LO:  reg_rdata = count_q[BYTE_W-1:0];
            REG_CNT_HI:  reg_rdata = count_q[PTR_W-1:BYTE_W];
            REG_CMD:     reg_rdata = cmd_q;
            REG_STAT:    reg_rdata = stat_byte;
            default:     reg_rdata = '0;
        endcase
    end

    // R9: the buffer is never written outside an active write transfer
    a_r9_no_idle_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != XF_WRITE) |-> !(we_lo || we_hi));
endmodule

// File: tb/test_rdma_port_engine.sv
`timescale 1ns/1ps
module test_rdma_port_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  reg_rdata;
    logic        word_mode = 1'b0;
    logic        port_rd = 1'b0;
    logic        port_wr = 1'b0;
    logic [15:0] port_wdata = 16'd0;
    logic [15:0] port_rdata;
    logic        done_flag;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] model [256];

    rdma_port_engine i_rdma_port_engine (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .word_mode(word_mode),
        .port_rd(port_rd), .port_wr(port_wr), .port_wdata(port_wdata),
        .port_rdata(port_rdata), .done_flag(done_flag)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual timeout expected completion");
        finish_run();
    end

    task automatic wreg(input logic [2:0] s, input logic [7:0] d);
        @(negedge clk);
        reg_sel = s; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rreg(input logic [2:0] s, output logic [7:0] d);
        reg_sel = s; #1; d = reg_rdata;
    endtask

    task automatic rd16(input logic [2:0] s, output logic [15:0] v);
        logic [7:0] lo, hi;
        rreg(s, lo); rreg(s + 3'd1, hi);
        v = {hi, lo};
    endtask

    task automatic pread(output logic [15:0] d);
        @(negedge clk);
        port_rd = 1'b1; #1; d = port_rdata;
        @(negedge clk);
        port_rd = 1'b0;
    endtask

    task automatic pwrite(input logic [15:0] d);
        @(negedge clk);
        port_wr = 1'b1; port_wdata = d;
        @(negedge clk);
        port_wr = 1'b0;
    endtask

    function automatic logic [15:0] end_addr(logic [15:0] a, logic [15:0] c, logic wm);
        logic [16:0] acc = wm ? ((17'(c) + 17'd1) >> 1) : 17'(c);
        return a + (wm ? 16'(acc << 1) : 16'(acc));
    endfunction

    task automatic setup(input logic [15:0] a, input logic [15:0] c, input logic wm);
        word_mode = wm;
        wreg(3'd5, 8'h40);
        wreg(3'd0, a[7:0]); wreg(3'd1, a[15:8]);
        wreg(3'd2, c[7:0]); wreg(3'd3, c[15:8]);
    endtask

    // Write transfer with model update and end-of-transfer checks
    task automatic run_write(input logic [15:0] a0, input logic [15:0] c0, input logic wm);
        logic [15:0] a = a0, rem = c0, v;
        logic [7:0] s;
        setup(a0, c0, wm);
        wreg(3'd4, 8'h12);
        while (rem != 0) begin
            v = 16'($urandom);
            pwrite(v);
            model[a[7:0]] = v[7:0];
            if (wm && rem > 1) model[8'(a[7:0] + 8'd1)] = v[15:8];
            a   = a + (wm ? 16'd2 : 16'd1);
            rem = (wm && rem > 1) ? rem - 16'd2 : rem - 16'd1;
        end
        check("R7 flag after write", 32'(done_flag), 32'd1);
        rreg(3'd5, s); check("R8 status bit6", 32'(s), 32'h40);
        rd16(3'd2, v); check("R7 count zero", 32'(v), 32'd0);
        rd16(3'd0, v); check("R6 end address", 32'(v), 32'(end_addr(a0, c0, wm)));
        pwrite(16'hDEAD); // ignored after completion (R9), seen by later reads
    endtask

    task automatic run_read(input logic [15:0] a0, input logic [15:0] c0, input logic wm);
        logic [15:0] a = a0, rem = c0, v, e;
        setup(a0, c0, wm);
        wreg(3'd4, 8'h0A);
        while (rem != 0) begin
            e = {8'h00, model[a[7:0]]};
            if (wm && rem > 1) e[15:8] = model[8'(a[7:0] + 8'd1)];
            pread(v);
            check(wm ? "R5 word read" : "R4 byte read", 32'(v), 32'(e));
            a   = a + (wm ? 16'd2 : 16'd1);
            rem = (wm && rem > 1) ? rem - 16'd2 : rem - 16'd1;
        end
        check("R7 flag after read", 32'(done_flag), 32'd1);
        pread(v); check("R9 read after done", 32'(v), 32'd0);
    endtask

    initial begin
        logic [7:0] b;
        logic [15:0] v;
        void'($urandom(32'h5EED_1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int s = 0; s < 6; s++) begin
            rreg(3'(s), b); check("R1 reset reg", 32'(b), 32'd0);
        end
        check("R1 reset flag", 32'(done_flag), 32'd0);
        check("R1 reset port", 32'(port_rdata), 32'd0);

        // R2 register load and read-back
        wreg(3'd0, 8'h34); wreg(3'd1, 8'h12); wreg(3'd2, 8'hCD); wreg(3'd3, 8'hAB);
        rd16(3'd0, v); check("R2 address", 32'(v), 32'h1234);
        rd16(3'd2, v); check("R2 count", 32'(v), 32'hABCD);

        // R4 fill the whole buffer byte by byte, R6 wraps through 0x00FF
        run_write(16'h0000, 16'd256, 1'b0);
        run_read(16'h0000, 16'd256, 1'b0);

        // R9 idle accesses: read zero, no write, no pointer movement
        setup(16'h0020, 16'd4, 1'b0);
        pwrite(16'h00EE);
        pread(v); check("R9 idle read zero", 32'(v), 32'd0);
        rd16(3'd0, v); check("R9 idle address kept", 32'(v), 32'h0020);
        rd16(3'd2, v); check("R9 idle count kept", 32'(v), 32'd4);
        // wrong direction during a read transfer
        wreg(3'd4, 8'h0A);
        pwrite(16'h00EE);
        rd16(3'd2, v); check("R9 wrong direction count", 32'(v), 32'd4);
        run_read(16'h0020, 16'd4, 1'b0);

        // R3 halt bit blocks the start
        setup(16'h0030, 16'd5, 1'b0);
        wreg(3'd4, 8'h13);
        pwrite(16'h0011);
        rd16(3'd2, v); check("R3 halt no start", 32'(v), 32'd5);
        rreg(3'd4, b); check("R3 command readback", 32'(b), 32'h13);

        // R10 abort mid-transfer
        setup(16'h0040, 16'd10, 1'b0);
        wreg(3'd4, 8'h12);
        for (int i = 0; i < 3; i++) begin
            v = 16'($urandom); pwrite(v); model[8'h40 + 8'(i)] = v[7:0];
        end
        wreg(3'd4, 8'h22);
        check("R10 no flag on abort", 32'(done_flag), 32'd0);
        rd16(3'd2, v); check("R10 count kept", 32'(v), 32'd7);
        rd16(3'd0, v); check("R10 address kept", 32'(v), 32'h0043);
        pwrite(16'h0077);
        run_read(16'h0040, 16'd10, 1'b0);

        // R5 odd count in word mode: last access writes the low lane only
        run_write(16'h0010, 16'd3, 1'b1);
        run_read(16'h0010, 16'd4, 1'b0);

        // R6 wrap of the 16-bit address in word mode
        run_write(16'hFFFE, 16'd5, 1'b1);
        rd16(3'd0, v); check("R6 wrapped address", 32'(v), 32'h0004);
        run_read(16'hFFFE, 16'd5, 1'b1);

        // R7 zero-count start flags at the command edge
        setup(16'h0050, 16'd0, 1'b1);
        check("R8 cleared before start", 32'(done_flag), 32'd0);
        wreg(3'd4, 8'h12);
        check("R7 zero count flag", 32'(done_flag), 32'd1);

        // R8 write-one-to-clear
        wreg(3'd5, 8'h00);
        check("R8 zero write keeps", 32'(done_flag), 32'd1);
        wreg(3'd5, 8'hBF);
        check("R8 other bits keep", 32'(done_flag), 32'd1);
        wreg(3'd5, 8'hFF);
        check("R8 all-ones clears", 32'(done_flag), 32'd0);
        wreg(3'd4, 8'h0A);
        wreg(3'd5, 8'h40);
        check("R8 bit6 clears", 32'(done_flag), 32'd0);

        // Random transfers mixing both modes
        for (int it = 0; it < 40; it++) begin
            logic [15:0] a = (it % 4 == 0) ? (16'hFFF0 + 16'($urandom % 16)) : 16'($urandom);
            logic [15:0] c = 16'($urandom % 24);
            run_write(a, c, 1'($urandom));
            run_read(a, c, 1'($urandom));
        end
        finish_run();
    end
endmodule